// File: doc/BRIEF.md
# Latched-Address One-Time-Programmable Byte ROM

This block models a 512-word by 8-bit read-only memory whose bits start at 0 and can be fused to 1 one time each. Every strobe is sampled by one system clock. A read starts when the active-low chip-select strobe goes low. The address is captured in that same cycle, and later changes on the address pins have no effect on that read. While the strobe stays low the decoders are live, and the output latch follows the selected word. When the strobe returns high the latch freezes, and the last word stays held until the next read starts.

The cells form a square 64-by-64 matrix. The upper six address bits pick a row and the lower three pick one byte-wide group inside that row. The data output drives only when three output enables are all asserted: two are active low and one is active high. Chip-select has no part in that decision. A separate flag shows that the latch holds a completed read.

A programming port ORs a byte mask into one addressed word in a single clock, but only while the program-enable input is high. Reads cannot begin while that input is high.

Top module: `otp_rom_core`

## Requirements
- R1: After reset every one of the 512 words reads as 8'h00.
- R2: Word address bits [8:3] select the row and bits [2:0] select the byte group within that row. Every one of the 512 addresses reaches its own storage.
- R3: The address captured for a read is the value on `addr` at the first clock edge where `ce_n` is sampled low. Address changes after that edge do not change the word returned.
- R4: `rd_valid` falls one edge after the first low sample of `ce_n`. The read word appears on the latch, with `rd_valid` high, at the second edge after that sample.
- R5: While `ce_n` is high the held word does not change, even if the array is programmed or the address moves.
- R6: While `ce_n` stays low the latch is reloaded from the addressed word on every clock, so programming during a read shows up one edge after the write.
- R7: `dq` and `q_drv` drive only if `rd_valid` is high and the enables sampled at the previous edge are all asserted: `oe1_n`=0, `oe2_n`=0 and `oe3`=1. Otherwise `dq` is high impedance, whatever `ce_n` is.
- R8: A programming write sets the stored word to its old value OR `prog_mask`, so stored bits are never cleared.
- R9: A `prog_req` with `prog_en` low leaves the array unchanged.
- R10: A falling `ce_n` is ignored when `prog_en` is high at the edge after `ce_n` was first sampled low. No read starts, and the latch and `rd_valid` keep their values.
- R11: During and right after reset, `rd_valid` and `q_drv` are 0 and `dq` is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip-select strobe |
| addr | input | 9 | Read word address |
| oe1_n | input | 1 | Output enable, active low |
| oe2_n | input | 1 | Output enable, active low |
| oe3 | input | 1 | Output enable, active high |
| prog_en | input | 1 | Programming permitted; must be low for reads |
| prog_req | input | 1 | Programming write request for one clock |
| prog_addr | input | 9 | Word address to program |
| prog_mask | input | 8 | Bits to set in the addressed word |
| dq | output | 8 | Three-state data output |
| q_drv | output | 1 | High while `dq` is driven |
| rd_valid | output | 1 | Output latch holds a completed read |

## Verification
The assertions assume that `rst_n` is low before the first edge and that `prog_en` stays steady across a chip-select falling edge. They also assume that every input changes only between clock edges. The bench drives all inputs on the falling clock edge, so each value is stable at the sampling edge. It raises `prog_en` only in the phases that test programming or blocking. In the random phase it keeps `prog_en` rare, so that falling edges both with and without it occur.

// File: rtl/otp_rom_pkg.sv
package otp_rom_pkg;

    // Output-enable inputs after one stage of sampling.
    typedef struct packed {
        logic g1_n;
        logic g2_n;
        logic g3;
    } oe_sync_t;

    localparam oe_sync_t OE_IDLE = '{g1_n: 1'b1, g2_n: 1'b1, g3: 1'b0};

    function automatic logic oe_granted(oe_sync_t v);
        return !v.g1_n && !v.g2_n && v.g3;
    endfunction

endpackage

// File: rtl/otp_strobe_ctrl.sv
module otp_strobe_ctrl
    import otp_rom_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              oe1_n_i,
    input  logic              oe2_n_i,
    input  logic              oe3_i,
    input  logic              prog_en_i,
    output logic              fall_o,
    output logic              active_o,
    output logic [ADDR_W-1:0] addr_lat_o,
    output logic              oe_all_o
);

    typedef struct packed {
        logic              ce_s;
        logic              ce_d1;
        logic [ADDR_W-1:0] addr_s;
        logic [ADDR_W-1:0] addr_lat;
        oe_sync_t          oe;
        logic              active;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     fall, rise;

    // Edge detection compares the sampled strobe with its delayed copy.
    assign fall = st_q.ce_d1 && !st_q.ce_s && !prog_en_i;
    assign rise = !st_q.ce_d1 && st_q.ce_s;

    always_comb begin
        st_d          = st_q;
        st_d.ce_s     = ce_n_i;
        st_d.ce_d1    = st_q.ce_s;
        st_d.addr_s   = addr_i;
        st_d.oe.g1_n  = oe1_n_i;
        st_d.oe.g2_n  = oe2_n_i;
        st_d.oe.g3    = oe3_i;
        if (fall) begin
            st_d.active   = 1'b1;
            st_d.addr_lat = st_q.addr_s;
        end else if (rise) begin
            st_d.active   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ce_s     <= 1'b1;
            st_q.ce_d1    <= 1'b1;
            st_q.addr_s   <= '0;
            st_q.addr_lat <= '0;
            st_q.oe       <= OE_IDLE;
            st_q.active   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fall_o     = fall;
    assign active_o   = st_q.active;
    assign addr_lat_o = st_q.addr_lat;
    assign oe_all_o   = oe_granted(st_q.oe);

    // R3: the latched address moves only when a new read is detected
    p_lat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !fall) |=> $stable(st_q.addr_lat));

    // R10: no read may begin while programming is enabled
    p_fall_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en_i && !st_q.active) |=> !st_q.active);

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
    parameter int DATA_W = 8,
    parameter int ROWS   = 64,
    parameter int COLS   = 64,
    parameter int ROW_W  = $clog2(ROWS),
    parameter int GRP_W  = $clog2(COLS / DATA_W),
    parameter int ADDR_W = ROW_W + GRP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              prog_en_i,
    input  logic              prog_req_i,
    input  logic [ADDR_W-1:0] prog_addr_i,
    input  logic [DATA_W-1:0] prog_mask_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int GROUPS = COLS / DATA_W;

    typedef struct packed {
        logic [ROWS-1:0][COLS-1:0] rows;
    } arr_st_t;

    arr_st_t st_d, st_q;

    logic [ROW_W-1:0]  rd_row, wr_row;
    logic [GRP_W-1:0]  rd_grp, wr_grp;
    logic [ROWS-1:0]   row_hit;
    logic [COLS-1:0]   row_bus;
    logic [COLS-1:0]   wr_vec;
    logic [DATA_W-1:0] grp_bus [GROUPS];
    logic              wr_en;

    assign rd_row = rd_addr_i[ADDR_W-1:GRP_W];
    assign rd_grp = rd_addr_i[GRP_W-1:0];
    assign wr_row = prog_addr_i[ADDR_W-1:GRP_W];
    assign wr_grp = prog_addr_i[GRP_W-1:0];
    assign wr_en  = prog_en_i && prog_req_i;
    assign wr_vec = COLS'(prog_mask_i) << (int'(wr_grp) * DATA_W);

    // Row decoder, gated off while no read is active.
    for (genvar r = 0; r < ROWS; r++) begin : g_row_dec
        assign row_hit[r] = rd_en_i && (rd_row == ROW_W'(r));
    end

    always_comb begin
        row_bus = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (row_hit[r]) row_bus = row_bus | st_q.rows[r];
        end
    end

    // Column groups feed the byte selector.
    for (genvar g = 0; g < GROUPS; g++) begin : g_col_grp
        assign grp_bus[g] = row_bus[g*DATA_W +: DATA_W];
    end

    assign rd_data_o = grp_bus[rd_grp];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int r = 0; r < ROWS; r++) begin
                if (wr_row == ROW_W'(r)) st_d.rows[r] = st_q.rows[r] | wr_vec;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: fused bits never return to zero
    p_set_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.rows & $past(st_q.rows)) == $past(st_q.rows)));

    // R9: without program enable the array is frozen
    p_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en_i |=> $stable(st_q.rows));

endmodule

// File: rtl/otp_out_stage.sv
module otp_out_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_i,
    input  logic              active_i,
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic              oe_all_i,
    output logic [DATA_W-1:0] word_o,
    output logic              valid_o,
    output logic              drv_o
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              valid;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fall_i) begin
            st_d.valid = 1'b0;
        end else if (active_i) begin
            st_d.word  = rd_data_i;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o  = st_q.word;
    assign valid_o = st_q.valid;
    assign drv_o   = st_q.valid && oe_all_i;

    // R5: outside a read the latch holds its word
    p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_i && !fall_i) |=> $stable(st_q.word));

    // R4: a newly detected read first drops the valid flag
    p_valid_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fall_i |=> !st_q.valid);

    // R4: the valid flag rises only from an active read
    p_valid_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.valid) |-> $past(active_i));

endmodule

// File: rtl/otp_rom_core.sv
module otp_rom_core #(
    parameter int DATA_W = 8,
    parameter int ROWS   = 64,
    parameter int COLS   = 64,
    parameter int ROW_W  = $clog2(ROWS),
    parameter int GRP_W  = $clog2(COLS / DATA_W),
    parameter int ADDR_W = ROW_W + GRP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              oe1_n,
    input  logic              oe2_n,
    input  logic              oe3,
    input  logic              prog_en,
    input  logic              prog_req,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_mask,
    output logic [DATA_W-1:0] dq,
    output logic              q_drv,
    output logic              rd_valid
);

    logic              fall, active, oe_all;
    logic [ADDR_W-1:0] addr_lat;
    logic [DATA_W-1:0] rd_data, word;

    otp_strobe_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n_i     (ce_n),
        .addr_i     (addr),
        .oe1_n_i    (oe1_n),
        .oe2_n_i    (oe2_n),
        .oe3_i      (oe3),
        .prog_en_i  (prog_en),
        .fall_o     (fall),
        .active_o   (active),
        .addr_lat_o (addr_lat),
        .oe_all_o   (oe_all)
    );

    otp_cell_array #(
        .DATA_W (DATA_W),
        .ROWS   (ROWS),
        .COLS   (COLS),
        .ROW_W  (ROW_W),
        .GRP_W  (GRP_W),
        .ADDR_W (ADDR_W)
    ) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en_i     (active),
        .rd_addr_i   (addr_lat),
        .prog_en_i   (prog_en),
        .prog_req_i  (prog_req),
        .prog_addr_i (prog_addr),
        .prog_mask_i (prog_mask),
        .rd_data_o   (rd_data)
    );

    otp_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_i    (fall),
        .active_i  (active),
        .rd_data_i (rd_data),
        .oe_all_i  (oe_all),
        .word_o    (word),
        .valid_o   (rd_valid),
        .drv_o     (q_drv)
    );

    assign dq = q_drv ? word : {DATA_W{1'bz}};

    // R7: driving the bus requires both a completed read and granted enables
    p_drive_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q_drv |-> (rd_valid && oe_all));

endmodule

// File: tb/otp_rom_core_tb_top.sv
module otp_rom_core_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 512;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ce_n, oe1_n, oe2_n, oe3, prog_en, prog_req;
    logic [8:0] addr, prog_addr;
    logic [7:0] prog_mask;
    wire  [7:0] dq;
    logic       q_drv, rd_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    otp_rom_core dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .addr(addr),
        .oe1_n(oe1_n), .oe2_n(oe2_n), .oe3(oe3),
        .prog_en(prog_en), .prog_req(prog_req), .prog_addr(prog_addr),
        .prog_mask(prog_mask), .dq(dq), .q_drv(q_drv), .rd_valid(rd_valid)
    );

    // Behavioural reference: a plain byte memory plus a few sampled strobes.
    int    mem [WORDS];
    int    m_ce_now, m_ce_old, m_addr_seen, m_lat, m_word;
    bit    m_active, m_valid;
    int    m_oe_ok;
    int    vectors = 0, miscompares = 0;
    string tag = "R11";
    bit    done = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (mem[i]) mem[i] = 0;
            m_ce_now = 1; m_ce_old = 1; m_addr_seen = 0; m_lat = 0;
            m_word = 0; m_active = 0; m_valid = 0; m_oe_ok = 0;
        end else begin
            bit starts, ends;
            int seen;
            starts = (m_ce_old == 1) && (m_ce_now == 0) && !prog_en;
            ends   = (m_ce_old == 0) && (m_ce_now == 1);
            seen   = m_active ? mem[m_lat] : 0;
            if (starts) m_valid = 0;
            else if (m_active) begin m_word = seen; m_valid = 1; end
            if (starts) begin m_active = 1; m_lat = m_addr_seen; end
            else if (ends) m_active = 0;
            if (prog_en && prog_req) mem[prog_addr] = mem[prog_addr] | prog_mask;
            m_ce_old    = m_ce_now;
            m_ce_now    = ce_n;
            m_addr_seen = addr;
            m_oe_ok     = (!oe1_n && !oe2_n && oe3) ? 1 : 0;
        end
    end

    task automatic compare();
        logic [7:0] exp_dq;
        bit         exp_drv;
        exp_drv = m_valid && (m_oe_ok == 1);
        exp_dq  = exp_drv ? 8'(m_word) : 8'hzz;
        vectors++;
        if (dq !== exp_dq || q_drv !== exp_drv || rd_valid !== m_valid) begin
            miscompares++;
            $display("FAIL %s: dq=%h drv=%b valid=%b expected dq=%h drv=%b valid=%b",
                     tag, dq, q_drv, rd_valid, exp_dq, exp_drv, m_valid);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic set_oe(input logic a, input logic b, input logic c);
        oe1_n = a; oe2_n = b; oe3 = c;
    endtask

    // Read: address present at the first low sample, then scrambled.
    task automatic do_read(input int a, input int hold);
        ce_n = 0; addr = 9'(a);
        tick();
        addr = ~9'(a);
        for (int i = 0; i < hold; i++) tick();
        ce_n = 1;
        tick(); tick(); tick();
    endtask

    task automatic do_prog(input int a, input int m);
        prog_en = 1; prog_req = 1; prog_addr = 9'(a); prog_mask = 8'(m);
        tick();
        prog_req = 0;
        tick();
        prog_en = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst_n = 0; ce_n = 1; addr = '0; prog_en = 0; prog_req = 0;
        prog_addr = '0; prog_mask = '0;
        set_oe(0, 0, 1);
        #(CLK_PERIOD * 3);
        @(negedge clk);
        compare();                         // R11 during reset
        rst_n = 1;
        for (int i = 0; i < 3; i++) tick(); // R11 after reset, enables on

        tag = "R1";
        do_read(0, 3);
        do_read(511, 3);
        do_read(300, 2);

        tag = "R8";
        do_prog(5, 8'h0F); do_read(5, 2);
        do_prog(5, 8'hF0); do_read(5, 2);
        do_prog(6, 8'h81); do_prog(6, 8'h01); do_prog(6, 8'h00); do_read(6, 2);

        tag = "R2";
        do_prog(9'h007, 8'h11); do_prog(9'h008, 8'h22);
        do_prog(9'h1FF, 8'h33); do_prog(9'h100, 8'h44); do_prog(9'h0F8, 8'h55);
        do_read(9'h007, 2); do_read(9'h008, 2); do_read(9'h1FF, 2);
        do_read(9'h100, 2); do_read(9'h0F8, 2); do_read(9'h0FF, 2);

        tag = "R3";
        do_read(9'h008, 5);
        do_read(9'h1FF, 1);

        tag = "R4";
        ce_n = 0; addr = 9'h007; tick(); tick(); tick(); ce_n = 1; tick(); tick();

        tag = "R5";
        do_read(9'h100, 2);
        do_prog(9'h100, 8'hFF);
        addr = 9'h1FF; tick(); tick();

        tag = "R6";
        ce_n = 0; addr = 9'h020; tick(); tick(); tick();
        prog_en = 1; prog_req = 1; prog_addr = 9'h020; prog_mask = 8'h3C; tick();
        prog_req = 0; prog_en = 0; tick(); tick();
        ce_n = 1; tick(); tick();

        tag = "R7";
        for (int c = 0; c < 8; c++) begin
            set_oe(c[0], c[1], c[2]); tick(); tick();
            ce_n = 0; tick(); tick();   // enables matter with the strobe low too
            ce_n = 1; tick(); tick();
        end
        set_oe(0, 0, 1);

        tag = "R9";
        prog_en = 0; prog_req = 1; prog_addr = 9'h030; prog_mask = 8'hFF; tick();
        prog_req = 0; tick();
        do_read(9'h030, 2);

        tag = "R10";
        do_read(9'h1FF, 2);
        prog_en = 1; ce_n = 0; addr = 9'h005; tick(); tick(); tick(); tick();
        ce_n = 1; tick(); tick(); prog_en = 0; tick();

        tag = "R6";
        for (int i = 0; i < 4000; i++) begin
            ce_n     = ($urandom_range(0, 3) != 0) ? ce_n : ~ce_n;
            addr     = 9'($urandom_range(0, 511));
            oe1_n    = ($urandom_range(0, 4) == 0);
            oe2_n    = ($urandom_range(0, 4) == 0);
            oe3      = ($urandom_range(0, 4) != 0);
            prog_en  = ($urandom_range(0, 9) == 0);
            prog_req = ($urandom_range(0, 1) == 0);
            prog_addr = 9'($urandom_range(0, 15) * 32 + $urandom_range(0, 7));
            prog_mask = 8'(1 << $urandom_range(0, 7));
            tick();
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule